// File: doc/BRIEF.md
# Two-Thread Allocation Arbiter with Thread-Mode Control

This block decides, every cycle, which of two hardware threads may send micro-ops into a shared out-of-order back end. A thread can be chosen only when it has work waiting and room in the back end. Work waiting means its micro-op queue is not empty. Room means neither its reorder buffer nor its reservation station reports full. When both threads qualify, a turn token makes the grant alternate between them. When only one thread qualifies, that thread takes the slot whatever the token says, so a stalled thread gives its whole allocation bandwidth to its sibling.

The block also tracks which threads are running. Each thread can halt or be woken by an interrupt. The set of running threads gives one of four modes: both threads running, only thread 0, only thread 1, or neither (low power). A thread that is halted is never granted. For each thread the block reports how many reorder-buffer entries and how many reservation-station entries it may use. Each thread gets half of each buffer while both run, the single running thread gets the whole buffer, and a halted thread gets nothing.

Top module: `alloc_pingpong_arb`

## Requirements
- R1: A thread is eligible only when its queue-not-empty bit is 1, its reorder-buffer-full bit is 0, its reservation-station-full bit is 0 and the thread is running. `grant` (bit 0 = thread 0, bit 1 = thread 1) is combinational from the current inputs, carries at most one set bit, and is 2'b00 when no thread is eligible.
- R2: When both threads are eligible, the grant goes to the thread that did not receive the previous grant, so on back-to-back cycles with both eligible the grant alternates.
- R3: When exactly one thread is eligible it is granted in that same cycle, whichever thread holds the turn.
- R4: The turn token resets to thread 0 and changes only on cycles that issue a grant; after a grant it points to the other thread. Cycles with no grant leave it unchanged.
- R5: `mode` encodes 2'b00 = both running, 2'b01 = only thread 0, 2'b10 = only thread 1, 2'b11 = low power. It is 2'b00 out of reset and updates on the clock edge after an event. From 2'b00, a halt of thread 0 gives 2'b10, a halt of thread 1 gives 2'b01, and halts of both in the same cycle give 2'b11.
- R6: A halt of the only running thread gives low power. An interrupt to a halted thread starts it again: from a single-thread mode this returns to 2'b00, and from low power it goes to the single-thread mode of the woken thread (2'b00 if both are woken at once).
- R7: A halt to a thread that is already halted, and an interrupt to a thread that is running, leave the mode unchanged.
- R8: In single-thread and low-power modes a halted thread is never granted, even when its three flags would make it eligible.
- R9: While both threads run, thread 0's limit for each buffer is floor(total/2) and thread 1's limit is total minus that value.
- R10: In a single-thread mode the running thread's limit for each buffer is the full total and the halted thread's limit is 0. In low power both limits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| uq_nonempty | input | 2 | Per-thread micro-op queue holds at least one entry |
| rob_full | input | 2 | Per-thread reorder buffer partition is full |
| rs_full | input | 2 | Per-thread reservation station partition is full |
| halt_evt | input | 2 | Per-thread halt event, one-cycle pulse |
| intr_evt | input | 2 | Per-thread interrupt event, one-cycle pulse |
| grant | output | 2 | One-hot allocation grant, or 2'b00 |
| mode | output | 2 | Current thread mode |
| rob_limit_t0 | output | ROB_W (8) | Reorder buffer entries thread 0 may use |
| rob_limit_t1 | output | ROB_W (8) | Reorder buffer entries thread 1 may use |
| rs_limit_t0 | output | RS_W (6) | Reservation station entries thread 0 may use |
| rs_limit_t1 | output | RS_W (6) | Reservation station entries thread 1 may use |

## Verification
The grant is due in the same cycle as the flags that produce it, judged against the mode and turn token held from earlier edges. A halt or interrupt changes `mode` and the limits only one edge later, and a grant changes the turn token, and so the next grant, only one edge later. The bench drives each cycle's inputs on the falling edge, compares grant, mode and all four limits a nanosecond later, and only then advances its own model of the running set and the token. That model therefore uses exactly the state the design holds when it is sampled.

// File: rtl/alloc_arb_pkg.sv
// Package: shared types and helpers for the two-thread allocation arbiter.
// Assumes exactly two hardware threads; the mode encoding is visible at
// the top-level ports, so it must not be reordered.
package alloc_arb_pkg;

    localparam int NUM_THREADS = 2;

    typedef enum logic [1:0] {
        MODE_BOTH  = 2'b00,
        MODE_ONLY0 = 2'b01,
        MODE_ONLY1 = 2'b10,
        MODE_SLEEP = 2'b11
    } thr_mode_e;

    // Map a running-thread vector (bit i = thread i runs) to a mode.
    function automatic thr_mode_e run_to_mode(input logic [NUM_THREADS-1:0] run);
        thr_mode_e m;
        case (run)
            2'b11:   m = MODE_BOTH;
            2'b01:   m = MODE_ONLY0;
            2'b10:   m = MODE_ONLY1;
            default: m = MODE_SLEEP;
        endcase
        return m;
    endfunction

    // Map a mode back to its running-thread vector.
    function automatic logic [NUM_THREADS-1:0] mode_to_run(input thr_mode_e m);
        logic [NUM_THREADS-1:0] r;
        case (m)
            MODE_BOTH:  r = 2'b11;
            MODE_ONLY0: r = 2'b01;
            MODE_ONLY1: r = 2'b10;
            default:    r = 2'b00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/thread_mode_fsm.sv
// Thread-mode state machine.
// Tracks which threads run. A running thread stops on its halt event and a
// stopped thread restarts on its interrupt; the other event is ignored for
// each thread. The mode register changes on the edge after the event.
// Assumes halt and interrupt events are single-cycle pulses.
module thread_mode_fsm
    import alloc_arb_pkg::*;
#(
    parameter int THREADS = NUM_THREADS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [THREADS-1:0] halt_evt,
    input  logic [THREADS-1:0] intr_evt,
    output thr_mode_e          mode,
    output logic [THREADS-1:0] running
);

    thr_mode_e          mode_q;
    logic [THREADS-1:0] run_next;

    assign running = mode_to_run(mode_q);
    assign mode    = mode_q;

    // Per-thread next running state: halt stops a runner, interrupt wakes a sleeper.
    for (genvar t = 0; t < THREADS; t++) begin : g_thr_next
        always_comb begin
            if (running[t]) begin
                run_next[t] = ~halt_evt[t];
            end else begin
                run_next[t] = intr_evt[t];
            end
        end
    end

    // Mode register: both threads running out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_BOTH;
        end else begin
            mode_q <= run_to_mode(run_next);
        end
    end

endmodule

// File: rtl/alloc_eligibility.sv
// Per-thread allocation eligibility.
// A thread is eligible when it runs, has queued micro-ops, and neither of its
// back-end partitions is full. Purely combinational.
module alloc_eligibility #(
    parameter int THREADS = 2
) (
    input  logic [THREADS-1:0] running,
    input  logic [THREADS-1:0] uq_nonempty,
    input  logic [THREADS-1:0] rob_full,
    input  logic [THREADS-1:0] rs_full,
    output logic [THREADS-1:0] eligible
);

    // One eligibility term per thread.
    for (genvar t = 0; t < THREADS; t++) begin : g_elig
        always_comb begin
            eligible[t] = running[t] & uq_nonempty[t] & ~rob_full[t] & ~rs_full[t];
        end
    end

endmodule

// File: rtl/pingpong_pick.sv
// Two-way ping-pong picker.
// Grants the token holder when both requesters are eligible, else the lone
// eligible one. The token passes to the other thread after each grant and
// holds still on idle cycles. Token starts at thread 0.
module pingpong_pick (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] eligible,
    output logic [1:0] grant
);

    logic turn_q;   // thread index that wins a tie

    // Grant selection: tie goes to the token holder.
    always_comb begin
        case (eligible)
            2'b11:   grant = turn_q ? 2'b10 : 2'b01;
            2'b01:   grant = 2'b01;
            2'b10:   grant = 2'b10;
            default: grant = 2'b00;
        endcase
    end

    // Token register: moves to the thread that was not just served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            turn_q <= 1'b0;
        end else if (grant[0]) begin
            turn_q <= 1'b1;
        end else if (grant[1]) begin
            turn_q <= 1'b0;
        end
    end

endmodule

// File: rtl/partition_limit.sv
// Partition limit generator for one shared buffer.
// Splits TOTAL entries between the threads from the current mode: a half
// each when both run (thread 1 takes the odd entry), everything for a lone
// runner, nothing for a halted thread.
module partition_limit
    import alloc_arb_pkg::*;
#(
    parameter int TOTAL = 128,
    parameter int W     = $clog2(TOTAL + 1)
) (
    input  thr_mode_e     mode,
    output logic [W-1:0]  limit_t0,
    output logic [W-1:0]  limit_t1
);

    localparam logic [W-1:0] FULL    = W'(TOTAL);
    localparam logic [W-1:0] HALF_LO = W'(TOTAL / 2);
    localparam logic [W-1:0] HALF_HI = W'(TOTAL - TOTAL / 2);

    // Limit selection by mode.
    always_comb begin
        case (mode)
            MODE_BOTH: begin
                limit_t0 = HALF_LO;
                limit_t1 = HALF_HI;
            end
            MODE_ONLY0: begin
                limit_t0 = FULL;
                limit_t1 = '0;
            end
            MODE_ONLY1: begin
                limit_t0 = '0;
                limit_t1 = FULL;
            end
            default: begin
                limit_t0 = '0;
                limit_t1 = '0;
            end
        endcase
    end

endmodule

// File: rtl/alloc_pingpong_arb.sv
// Two-thread allocation arbiter, top level.
// Combines the thread-mode machine, per-thread eligibility, the ping-pong
// picker and two partition limit generators (reorder buffer and reservation
// station). Grant is same-cycle; mode and limits follow events by one edge.
module alloc_pingpong_arb
    import alloc_arb_pkg::*;
#(
    parameter int ROB_TOTAL = 128,
    parameter int RS_TOTAL  = 54,
    localparam int ROB_W    = $clog2(ROB_TOTAL + 1),
    localparam int RS_W     = $clog2(RS_TOTAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       uq_nonempty,
    input  logic [1:0]       rob_full,
    input  logic [1:0]       rs_full,
    input  logic [1:0]       halt_evt,
    input  logic [1:0]       intr_evt,
    output logic [1:0]       grant,
    output logic [1:0]       mode,
    output logic [ROB_W-1:0] rob_limit_t0,
    output logic [ROB_W-1:0] rob_limit_t1,
    output logic [RS_W-1:0]  rs_limit_t0,
    output logic [RS_W-1:0]  rs_limit_t1
);

    thr_mode_e  cur_mode;
    logic [1:0] running;
    logic [1:0] eligible;

    thread_mode_fsm #(.THREADS(2)) u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .halt_evt (halt_evt),
        .intr_evt (intr_evt),
        .mode     (cur_mode),
        .running  (running)
    );

    alloc_eligibility #(.THREADS(2)) u_elig (
        .running     (running),
        .uq_nonempty (uq_nonempty),
        .rob_full    (rob_full),
        .rs_full     (rs_full),
        .eligible    (eligible)
    );

    pingpong_pick u_pick (
        .clk      (clk),
        .rst_n    (rst_n),
        .eligible (eligible),
        .grant    (grant)
    );

    partition_limit #(.TOTAL(ROB_TOTAL), .W(ROB_W)) u_rob_lim (
        .mode     (cur_mode),
        .limit_t0 (rob_limit_t0),
        .limit_t1 (rob_limit_t1)
    );

    partition_limit #(.TOTAL(RS_TOTAL), .W(RS_W)) u_rs_lim (
        .mode     (cur_mode),
        .limit_t0 (rs_limit_t0),
        .limit_t1 (rs_limit_t1)
    );

    assign mode = cur_mode;

endmodule

// File: rtl/alloc_pingpong_arb_chk.sv
// Checker for alloc_pingpong_arb, attached by bind. Observes ports only.
module alloc_pingpong_arb_chk #(
    parameter int ROB_TOTAL = 128,
    parameter int RS_TOTAL  = 54,
    parameter int ROB_W     = 8,
    parameter int RS_W      = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       uq_nonempty,
    input logic [1:0]       rob_full,
    input logic [1:0]       rs_full,
    input logic [1:0]       halt_evt,
    input logic [1:0]       intr_evt,
    input logic [1:0]       grant,
    input logic [1:0]       mode,
    input logic [ROB_W-1:0] rob_limit_t0,
    input logic [ROB_W-1:0] rob_limit_t1,
    input logic [RS_W-1:0]  rs_limit_t0,
    input logic [RS_W-1:0]  rs_limit_t1
);

    logic live;   // previous cycle was out of reset
    logic can0, can1;

    // Track one full cycle out of reset so $past refers to live cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    assign can0 = uq_nonempty[0] && !rob_full[0] && !rs_full[0] && (mode == 2'b00 || mode == 2'b01);
    assign can1 = uq_nonempty[1] && !rob_full[1] && !rs_full[1] && (mode == 2'b00 || mode == 2'b10);

    assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_needs_work_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != 2'b00) |-> ((grant[0] && uq_nonempty[0] && !rob_full[0] && !rs_full[0]) ||
                              (grant[1] && uq_nonempty[1] && !rob_full[1] && !rs_full[1])));
    assert_alternate_after0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && can0 && can1 && $past(grant) == 2'b01) |-> grant == 2'b10);
    assert_alternate_after1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (live && can0 && can1 && $past(grant) == 2'b10) |-> grant == 2'b01);
    assert_lone_granted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (can0 != can1) |-> grant == {can1, can0});
    assert_halt0_from_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && halt_evt == 2'b01) |=> mode == 2'b10);
    assert_last_halt_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && halt_evt == 2'b10 && !intr_evt[0]) |=> mode == 2'b11);
    assert_wake_from_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && intr_evt == 2'b01) |=> mode == 2'b01);
    assert_ignored_events_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && halt_evt == 2'b01 && intr_evt == 2'b10) |=> mode == 2'b10);
    assert_halted_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == 2'b01 && !grant[1]) || (mode == 2'b10 && !grant[0]) ||
         (mode == 2'b11 && grant == 2'b00) || mode == 2'b00));
    assert_even_split_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> (int'(rob_limit_t0) + int'(rob_limit_t1) == ROB_TOTAL &&
                             int'(rs_limit_t0) + int'(rs_limit_t1) == RS_TOTAL));
    assert_lone_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |-> (int'(rob_limit_t0) == ROB_TOTAL && rob_limit_t1 == '0 &&
                             int'(rs_limit_t0) == RS_TOTAL && rs_limit_t1 == '0));

endmodule

bind alloc_pingpong_arb alloc_pingpong_arb_chk #(
    .ROB_TOTAL (ROB_TOTAL),
    .RS_TOTAL  (RS_TOTAL),
    .ROB_W     (ROB_W),
    .RS_W      (RS_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .uq_nonempty  (uq_nonempty),
    .rob_full     (rob_full),
    .rs_full      (rs_full),
    .halt_evt     (halt_evt),
    .intr_evt     (intr_evt),
    .grant        (grant),
    .mode         (mode),
    .rob_limit_t0 (rob_limit_t0),
    .rob_limit_t1 (rob_limit_t1),
    .rs_limit_t0  (rs_limit_t0),
    .rs_limit_t1  (rs_limit_t1)
);

// File: tb/alloc_pingpong_arb_tb_top.sv
`timescale 1ns/1ps
module alloc_pingpong_arb_tb_top;

    localparam int ROB_T = 128;
    localparam int RS_T  = 54;
    localparam int ROB_W = $clog2(ROB_T + 1);
    localparam int RS_W  = $clog2(RS_T + 1);

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       uq_nonempty, rob_full, rs_full, halt_evt, intr_evt;
    logic [1:0]       grant, mode;
    logic [ROB_W-1:0] rob_limit_t0, rob_limit_t1;
    logic [RS_W-1:0]  rs_limit_t0, rs_limit_t1;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;
    bit  run0, run1;   // model: which threads run
    int  turn;         // model: thread that wins a tie

    always #2.5 clk = ~clk;

    alloc_pingpong_arb #(.ROB_TOTAL(ROB_T), .RS_TOTAL(RS_T)) dut_i (
        .clk (clk), .rst_n (rst_n),
        .uq_nonempty (uq_nonempty), .rob_full (rob_full), .rs_full (rs_full),
        .halt_evt (halt_evt), .intr_evt (intr_evt),
        .grant (grant), .mode (mode),
        .rob_limit_t0 (rob_limit_t0), .rob_limit_t1 (rob_limit_t1),
        .rs_limit_t0 (rs_limit_t0), .rs_limit_t1 (rs_limit_t1)
    );

    task automatic check(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Drive one cycle, compare every output against the model, then advance the model.
    task automatic step(string tag, logic [1:0] ne, logic [1:0] rf, logic [1:0] sf,
                        logic [1:0] h, logic [1:0] i);
        bit e0, e1;
        int g, m, r0, r1, s0, s1;
        string lt;
        @(negedge clk);
        uq_nonempty = ne; rob_full = rf; rs_full = sf; halt_evt = h; intr_evt = i;
        #1;
        e0 = run0 && ne[0] && !rf[0] && !sf[0];
        e1 = run1 && ne[1] && !rf[1] && !sf[1];
        if (e0 && e1)  g = (turn == 0) ? 1 : 2;
        else if (e0)   g = 1;
        else if (e1)   g = 2;
        else           g = 0;
        if (run0 && run1) m = 0; else if (run0) m = 1; else if (run1) m = 2; else m = 3;
        check(tag, "grant", int'(grant), g);
        check(tag, "mode", int'(mode), m);
        if (m == 0) begin
            lt = "R9";
            r0 = ROB_T / 2; r1 = ROB_T - ROB_T / 2; s0 = RS_T / 2; s1 = RS_T - RS_T / 2;
        end else begin
            lt = "R10";
            r0 = run0 ? ROB_T : 0; r1 = run1 ? ROB_T : 0;
            s0 = run0 ? RS_T : 0;  s1 = run1 ? RS_T : 0;
        end
        check(lt, "rob_limit_t0", int'(rob_limit_t0), r0);
        check(lt, "rob_limit_t1", int'(rob_limit_t1), r1);
        check(lt, "rs_limit_t0", int'(rs_limit_t0), s0);
        check(lt, "rs_limit_t1", int'(rs_limit_t1), s1);
        if (g == 1) turn = 1;
        else if (g == 2) turn = 0;
        run0 = run0 ? !h[0] : i[0];
        run1 = run1 ? !h[1] : i[1];
    endtask

    initial begin
        rst_n = 1'b0;
        uq_nonempty = '0; rob_full = '0; rs_full = '0; halt_evt = '0; intr_evt = '0;
        run0 = 1; run1 = 1; turn = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // Reset state: both running, no work, token at thread 0.
        step("R5", 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
        // Both eligible: first tie goes to thread 0, then alternate.
        step("R4", 2'b11, 2'b00, 2'b00, 2'b00, 2'b00);
        for (int k = 0; k < 4; k++) step("R2", 2'b11, 2'b00, 2'b00, 2'b00, 2'b00);
        // Blocked by full buffers or empty queues.
        step("R1", 2'b11, 2'b01, 2'b00, 2'b00, 2'b00);
        step("R1", 2'b11, 2'b00, 2'b10, 2'b00, 2'b00);
        step("R1", 2'b11, 2'b11, 2'b11, 2'b00, 2'b00);
        step("R1", 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
        // Lone thread 1 keeps winning regardless of turn.
        for (int k = 0; k < 3; k++) step("R3", 2'b10, 2'b00, 2'b00, 2'b00, 2'b00);
        // Idle cycles hold the token, then a tie resolves from it.
        step("R4", 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
        step("R4", 2'b11, 2'b00, 2'b00, 2'b00, 2'b00);
        // Halt thread 0 from both-running mode.
        step("R5", 2'b11, 2'b00, 2'b00, 2'b01, 2'b00);
        step("R8", 2'b11, 2'b00, 2'b00, 2'b00, 2'b00);
        step("R8", 2'b01, 2'b00, 2'b00, 2'b00, 2'b00);
        // Ignored events: halt to halted thread, interrupt to running thread.
        step("R7", 2'b11, 2'b00, 2'b00, 2'b01, 2'b10);
        step("R7", 2'b11, 2'b00, 2'b00, 2'b00, 2'b00);
        // Wake thread 0 back to both running.
        step("R6", 2'b00, 2'b00, 2'b00, 2'b00, 2'b01);
        step("R6", 2'b11, 2'b00, 2'b00, 2'b00, 2'b00);
        // Halt thread 1, then thread 0: low power.
        step("R5", 2'b00, 2'b00, 2'b00, 2'b10, 2'b00);
        step("R8", 2'b11, 2'b00, 2'b00, 2'b01, 2'b00);
        step("R8", 2'b11, 2'b00, 2'b00, 2'b00, 2'b00);
        // Wake thread 1 from low power, halt it again, wake both.
        step("R6", 2'b11, 2'b00, 2'b00, 2'b00, 2'b10);
        step("R6", 2'b11, 2'b00, 2'b00, 2'b10, 2'b00);
        step("R6", 2'b11, 2'b00, 2'b00, 2'b00, 2'b11);
        step("R6", 2'b11, 2'b00, 2'b00, 2'b00, 2'b00);
        // Simultaneous halts from both-running mode.
        step("R5", 2'b11, 2'b00, 2'b00, 2'b11, 2'b00);
        step("R8", 2'b11, 2'b00, 2'b00, 2'b00, 2'b01);
        step("R6", 2'b11, 2'b00, 2'b00, 2'b00, 2'b10);
        // Mixed traffic with sparse events.
        for (int k = 0; k < 600; k++) begin
            logic [1:0] h, i;
            h = {($urandom % 16) == 0, ($urandom % 16) == 0};
            i = {($urandom % 8) == 0, ($urandom % 8) == 0};
            step("R2", 2'($urandom), 2'($urandom & $urandom), 2'($urandom & $urandom), h, i);
        end
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule